// File: doc/BRIEF.md
# External Bus Release Arbiter

This block hands the external memory bus to another bus master on request and takes it back afterwards. The outside device pulls an active-low request line. The block answers on an active-low acknowledge line once every address, data, chip-select and strobe pad it controls has stopped driving. While the bus is handed over, the on-chip master keeps working on internal resources. Any external access it asks for is held back until the outside device lets go.

Software allows hand-over with an enable bit. The request pin is resynchronised to the local clock before it is used. The switch happens only between external bus cycles, and the acknowledge edges are placed so that the two masters never drive the bus together. The external bus cycle engine and the pad cells sit outside this block. The block only gives the engine a launch pulse, reads its busy flag and supplies one output-enable per pad group.

Top module: `xbus_yield_arb`

## Requirements
- R1: While `yield_en` is 0, the request pin has no effect: `hold_ack_n` stays 1 and every `pad_oe` bit stays 1, and external launches still proceed.
- R2: A request is the condition `yield_en`=1 with `hold_req_n`=0, taken through a SYNC_STAGES-flop synchronizer. With the default of 2 stages and an idle bus, `hold_ack_n` goes to 0 at the 4th rising edge after `hold_req_n` falls.
- R3: Whenever `hold_ack_n` is 0, every bit of `pad_oe` is 0 (address, data, chip-select and strobe pads all at high impedance).
- R4: `hold_ack_n` falls only one clock after `pad_oe` went to 0. In the cycle before acknowledge falls, `pad_oe` is already 0; by default this is the 3rd edge after the request.
- R5: After `hold_req_n` returns high, `hold_ack_n` rises at the 3rd rising edge (default stages). `pad_oe` returns to all-ones one edge after that, so acknowledge is high for one cycle before the pads drive again.
- R6: An internal access (`mst_req`=1, `mst_ext`=0) never sees `mst_wait`=1, including while the bus is released.
- R7: An external access requested while the bus is handed over (or being handed over or back) gets `mst_wait`=1 and no `xcyc_go`. It is launched (`xcyc_go`=1) in the first cycle in which `pad_oe` is all-ones again.
- R8: In a cycle where a synchronised request is active and the on-chip master also requests an external access, the release wins: `xcyc_go` stays 0 and `pad_oe` goes to 0 at the next edge.
- R9: Release is granted only at a bus-cycle boundary. While `xcyc_busy` is 1, `pad_oe` stays all-ones and `hold_ack_n` stays 1. The edge that first sees `xcyc_busy`=0 clears `pad_oe`, and acknowledge falls one edge later.
- R10: `xcyc_go` is never 1 while `xcyc_busy` is 1. An access waiting on a busy engine shows `mst_wait`=1 and launches in the first cycle that `xcyc_busy` is 0.
- R11: During and right after reset, `hold_ack_n`=1, `pad_oe` is all-ones, and no release is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| yield_en | input | 1 | Software enable for bus hand-over |
| hold_req_n | input | 1 | Active-low bus request from the outside master (asynchronous) |
| hold_ack_n | output | 1 | Active-low acknowledge: bus handed over |
| mst_req | input | 1 | On-chip master access request, held until served |
| mst_ext | input | 1 | 1 when the requested access targets the external bus |
| mst_wait | output | 1 | Stall for the on-chip master's external access |
| xcyc_go | output | 1 | Launch pulse to the external bus cycle engine |
| xcyc_busy | input | 1 | External bus cycle in progress |
| pad_oe | output | OE_GROUPS (4) | Output enables: address, data, chip-select, strobe pad groups |

## Verification
The directed patterns each isolate one thing. A request with the enable clear shows that the gate works. A request on an idle bus fixes the exact edges for tri-state, acknowledge and reclaim. A request while an engine cycle is busy shows that hand-over is delayed to the cycle boundary. An external access that coincides with an active request separates the priority order from plain deferral. A seeded random phase then toggles the request, the enable, the access type and the engine busy time together. Every cycle it checks the non-overlap ordering and that internal accesses never stall, which exposes any corner where both masters could drive at once.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

   typedef enum logic [2:0] {
      XB_OWN     = 3'd0,
      XB_DRAIN   = 3'd1,
      XB_HIZ     = 3'd2,
      XB_YIELD   = 3'd3,
      XB_RECLAIM = 3'd4
   } xbr_state_t;

endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("xbr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/xbr_fsm.sv
module xbr_fsm
   import xbr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_act,
   input  logic       cyc_busy,
   output xbr_state_t state,
   output logic       ack_n,
   output logic       drive
);

   xbr_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         XB_OWN:     if (hold_act) nxt = cyc_busy ? XB_DRAIN : XB_HIZ;
         XB_DRAIN:   if (!hold_act)     nxt = XB_OWN;
                     else if (!cyc_busy) nxt = XB_HIZ;
         XB_HIZ:     nxt = XB_YIELD;
         XB_YIELD:   if (!hold_act) nxt = XB_RECLAIM;
         XB_RECLAIM: nxt = XB_OWN;
         default:    nxt = XB_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= XB_OWN;
         ack_n <= 1'b1;
         drive <= 1'b1;
      end else begin
         state <= nxt;
         ack_n <= (nxt != XB_YIELD);
         drive <= (nxt == XB_OWN) || (nxt == XB_DRAIN);
      end
   end

   // R3: pads quiet whenever the outside master holds the bus
   a_r3_released_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> !drive);

   // R4: pads went quiet a full cycle before acknowledge falls
   a_r4_hiz_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n) |-> !$past(drive));

   // R5: acknowledge was already high the cycle before pads drive again
   a_r5_ack_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive) |-> $past(ack_n));

   // R9: no hand-over while an engine cycle is running
   a_r9_cycle_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_busy && drive) |=> drive);

endmodule

// File: rtl/xbr_launch.sv
module xbr_launch
   import xbr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  xbr_state_t state,
   input  logic       hold_act,
   input  logic       cyc_busy,
   input  logic       mst_req,
   input  logic       mst_ext,
   output logic       cyc_go,
   output logic       mst_wait
);

   logic ext_ask;
   logic may_launch;

   assign ext_ask    = mst_req && mst_ext;
   // release request outranks a launch in the same cycle
   assign may_launch = (state == XB_OWN) && !hold_act && !cyc_busy;
   assign cyc_go     = ext_ask && may_launch;
   assign mst_wait   = ext_ask && !may_launch;

   // R6: internal work is never stalled
   a_r6_internal_free: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_req && !mst_ext) |-> (!mst_wait && !cyc_go));

   // R10: never launch on top of a running engine cycle
   a_r10_no_overlap_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_go |-> !cyc_busy);

endmodule

// File: rtl/xbus_yield_arb.sv
module xbus_yield_arb
   import xbr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OE_GROUPS   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 yield_en,
   input  logic                 hold_req_n,
   output logic                 hold_ack_n,
   input  logic                 mst_req,
   input  logic                 mst_ext,
   output logic                 mst_wait,
   output logic                 xcyc_go,
   input  logic                 xcyc_busy,
   output logic [OE_GROUPS-1:0] pad_oe
);

   generate
      if (OE_GROUPS < 1) begin : g_bad_groups
         $error("xbus_yield_arb: OE_GROUPS must be at least 1");
      end
   endgenerate

   logic       req_pin_s;
   logic       hold_act;
   logic       drive;
   xbr_state_t state;

   xbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hold_req_n),
      .q     (req_pin_s)
   );

   assign hold_act = yield_en && !req_pin_s;

   xbr_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_act (hold_act),
      .cyc_busy (xcyc_busy),
      .state    (state),
      .ack_n    (hold_ack_n),
      .drive    (drive)
   );

   xbr_launch u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .hold_act (hold_act),
      .cyc_busy (xcyc_busy),
      .mst_req  (mst_req),
      .mst_ext  (mst_ext),
      .cyc_go   (xcyc_go),
      .mst_wait (mst_wait)
   );

   generate
      for (genvar g = 0; g < OE_GROUPS; g++) begin : g_oe
         assign pad_oe[g] = drive;
      end
   endgenerate

   // R1: with the enable clear, a driving bus is never handed over
   a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!yield_en && (&pad_oe)) |=> hold_ack_n);

   // R7: launches happen only with pads driven and acknowledge high
   a_r7_launch_owned: assert property (@(posedge clk) disable iff (!rst_n)
      xcyc_go |-> ((&pad_oe) && hold_ack_n));

   // R8: an active request with a pending external access goes to release
   a_r8_release_first: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && (&pad_oe) && hold_ack_n && !xcyc_busy && mst_req && mst_ext)
      |-> (!xcyc_go ##1 !(|pad_oe)));

endmodule

// File: tb/xbus_yield_arb_bench.sv
module xbus_yield_arb_bench;

   localparam int NG = 4;
   localparam logic [NG-1:0] ALL_ON = {NG{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n;
   logic          yield_en, hold_req_n, mst_req, mst_ext, xcyc_busy;
   logic          hold_ack_n, mst_wait, xcyc_go;
   logic [NG-1:0] pad_oe;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   xbus_yield_arb #(.SYNC_STAGES(2), .OE_GROUPS(NG)) u_xbus_yield_arb (
      .clk(clk), .rst_n(rst_n), .yield_en(yield_en), .hold_req_n(hold_req_n),
      .hold_ack_n(hold_ack_n), .mst_req(mst_req), .mst_ext(mst_ext),
      .mst_wait(mst_wait), .xcyc_go(xcyc_go), .xcyc_busy(xcyc_busy),
      .pad_oe(pad_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic mid;
      @(negedge clk);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   function automatic bit oe_consistent(input logic [NG-1:0] v);
      return (v == ALL_ON) || (v == '0);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int releases;
      int busy_left;
      bit go_seen;
      logic prev_ack, prev_on, prev_off;

      void'($urandom(32'd2718));
      rst_n = 1'b0; yield_en = 1'b0; hold_req_n = 1'b1;
      mst_req = 1'b0; mst_ext = 1'b0; xcyc_busy = 1'b0;
      tick(3);
      mid();
      // R11 reset state
      chk("R11 ack in reset", hold_ack_n, 1);
      chk("R11 pads in reset", pad_oe, ALL_ON);
      chk("R11 no launch in reset", xcyc_go, 0);
      rst_n = 1'b1;
      tick(1);
      mid();
      chk("R11 pads after reset", pad_oe, ALL_ON);

      // R1: enable clear, pin ignored
      hold_req_n = 1'b0;
      tick(8);
      mid();
      chk("R1 ack stays high", hold_ack_n, 1);
      chk("R1 pads stay on", pad_oe, ALL_ON);
      tick(1);
      mst_req = 1'b1; mst_ext = 1'b1;
      mid();
      chk("R1 external launch proceeds", xcyc_go, 1);
      tick(1);
      mst_req = 1'b0; hold_req_n = 1'b1;
      tick(4);

      // R2 R3 R4: idle-bus hand-over edges
      yield_en = 1'b1;
      hold_req_n = 1'b0;
      tick(2);
      mid();
      chk("R4 pads still on after 2 edges", pad_oe, ALL_ON);
      tick(1);
      mid();
      chk("R4 pads off at edge 3", pad_oe, 0);
      chk("R4 ack still high at edge 3", hold_ack_n, 1);
      tick(1);
      mid();
      chk("R2 ack low at edge 4", hold_ack_n, 0);
      chk("R3 pads off while released", pad_oe, 0);

      // R6 R7 during release
      mst_req = 1'b1; mst_ext = 1'b0;
      mid();
      chk("R6 internal no wait", mst_wait, 0);
      tick(1);
      mst_ext = 1'b1;
      mid();
      chk("R7 external deferred wait", mst_wait, 1);
      chk("R7 external deferred no go", xcyc_go, 0);

      // R5: release end
      tick(1);
      hold_req_n = 1'b1;
      tick(2);
      mid();
      chk("R5 ack low after 2 edges", hold_ack_n, 0);
      tick(1);
      mid();
      chk("R5 ack high at edge 3", hold_ack_n, 1);
      chk("R5 pads still off at edge 3", pad_oe, 0);
      chk("R7 no go before pads on", xcyc_go, 0);
      tick(1);
      mid();
      chk("R5 pads on at edge 4", pad_oe, ALL_ON);
      chk("R7 deferred launch first driven cycle", xcyc_go, 1);
      tick(1);
      mst_req = 1'b0;
      tick(2);

      // R8: request active in same cycle as external access
      hold_req_n = 1'b0;
      tick(2);
      mst_req = 1'b1; mst_ext = 1'b1;
      mid();
      chk("R8 release wins no go", xcyc_go, 0);
      chk("R8 master waits", mst_wait, 1);
      tick(1);
      mid();
      chk("R8 pads off next edge", pad_oe, 0);
      tick(1);
      mid();
      chk("R8 ack low", hold_ack_n, 0);
      hold_req_n = 1'b1;
      tick(4);
      mid();
      chk("R8 access launched after return", xcyc_go, 1);
      tick(1);
      mst_req = 1'b0;
      tick(2);

      // R10: busy engine blocks launch
      xcyc_busy = 1'b1; mst_req = 1'b1; mst_ext = 1'b1;
      mid();
      chk("R10 no go while busy", xcyc_go, 0);
      chk("R10 wait while busy", mst_wait, 1);
      tick(1);
      xcyc_busy = 1'b0;
      mid();
      chk("R10 go once idle", xcyc_go, 1);
      tick(1);
      mst_req = 1'b0;

      // R9: hand-over waits for cycle boundary
      xcyc_busy = 1'b1;
      hold_req_n = 1'b0;
      tick(6);
      mid();
      chk("R9 pads on while busy", pad_oe, ALL_ON);
      chk("R9 ack high while busy", hold_ack_n, 1);
      xcyc_busy = 1'b0;
      tick(1);
      mid();
      chk("R9 pads off after busy ends", pad_oe, 0);
      tick(1);
      mid();
      chk("R9 ack low after boundary", hold_ack_n, 0);
      hold_req_n = 1'b1;
      tick(4);
      mid();
      chk("R9 pads back", pad_oe, ALL_ON);

      // random phase
      releases = 0; busy_left = 0;
      prev_ack = 1'b1; prev_on = 1'b1; prev_off = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         mid();
         if (!oe_consistent(pad_oe)) chk("R3 pad groups agree", pad_oe, ALL_ON);
         if (!hold_ack_n) chk("R3 released pads off", pad_oe, 0);
         if (prev_ack && !hold_ack_n) begin
            releases++;
            chk("R4 pads off before ack fell", {31'd0, prev_off}, 1);
         end
         if (prev_off && pad_oe == ALL_ON) chk("R5 ack high before drive", {31'd0, prev_ack}, 1);
         if (mst_req && !mst_ext) chk("R6 internal no stall", {30'd0, mst_wait, xcyc_go}, 0);
         if (xcyc_go) begin
            chk("R7 go only when owned", {30'd0, (pad_oe == ALL_ON), hold_ack_n}, 3);
            chk("R10 go only when idle", xcyc_busy, 0);
         end
         if (!hold_ack_n && mst_req && mst_ext) chk("R7 wait while released", mst_wait, 1);
         if (!yield_en && prev_on && pad_oe == ALL_ON) chk("R1 enable clear keeps ack", hold_ack_n, 1);
         prev_ack = hold_ack_n;
         prev_on  = (pad_oe == ALL_ON);
         prev_off = (pad_oe == '0);
         go_seen  = xcyc_go;
         tick(1);
         if (go_seen) busy_left = $urandom_range(1, 4);
         else if (busy_left > 0) busy_left--;
         xcyc_busy = (busy_left > 0);
         if (!mst_req || go_seen || !mst_ext) begin
            mst_req = ($urandom_range(0, 2) != 0);
            mst_ext = $urandom_range(0, 1) != 0;
         end
         if ($urandom_range(0, 19) == 0) hold_req_n = ~hold_req_n;
         if ($urandom_range(0, 299) == 0) yield_en = ~yield_en;
      end
      chk("R2 random phase saw releases", {31'd0, releases > 5}, 1);
      summary();
   end

endmodule